// File: doc/BRIEF.md
# Address-Masked GPIO with Line Interrupts

An eight-line general-purpose I/O block on a simple byte-wide memory-mapped bus. Each line can be an input or an output. Pin data goes through an address-masked window: the word-address bits of a data access form a per-pin mask, so software can set, clear or sample any subset of lines in one access with no read-modify-write. The pads appear as separate input, output and output-enable vectors.

Every line has an interrupt detector. It works on a two-flop synchronised copy of the pad input. Three configuration bits per line pick level or edge sensing, single or both edges, and the active polarity. Edge events are latched until a write-one-to-clear access removes them. Level conditions are never latched. An enable register masks the raw status, and one output is raised while any masked bit is set.

Bus reads are combinational: `rdata_o` is valid in the same cycle as a read request. Writes take effect at the clock edge that ends the request cycle.

Top module: `gpio_mask_irq`

## Requirements
- R1: After reset, every register is 0. `gpio_oe_o`, `gpio_o` and `irq_o` are 0, and reads of direction, enable and raw status return 0.
- R2: A write with `addr_i[11:10]==0` updates only the output bits whose mask bit `addr_i[9:2]` is 1. Output bits outside the mask keep their value.
- R3: A read with `addr_i[11:10]==0` returns 0 in unmasked positions. In masked positions it returns the line value: the output bit for an output line, or the pad input delayed by two clock edges for an input line.
- R4: Direction register (0x400): a 1 makes the line an output. `gpio_oe_o` equals this register from the cycle after the write, and `gpio_o` always shows the output bits.
- R5: With sense (0x404) = 1, the line is level-sensitive. Its raw status is 1 while the synchronised input equals its event bit (0x40C), where 1 means high and 0 means low. It drops by itself when the condition ends, and a clear write does not change it.
- R6: With sense = 0 and both-edges (0x408) = 0, event bit 1 latches a rising edge and event bit 0 latches a falling edge. The opposite edge sets nothing.
- R7: With sense = 0 and both-edges = 1, either edge latches the line, whatever its event bit holds.
- R8: Writing the clear register (0x41C) removes the latched edge for each bit written 1. Bits written 0 have no effect.
- R9: If an edge is detected on a line in the same cycle as a clear of that line, the line stays latched.
- R10: Masked status (0x418) reads raw AND enable (0x410). `irq_o` is 1 exactly when the masked status is nonzero.
- R11: Raw status (0x414) and masked status ignore writes. The clear register and unmapped offsets from 0x420 upward read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the request cycle |
| gpio_i | input | 8 | Pad inputs |
| gpio_o | output | 8 | Pad output values |
| gpio_oe_o | output | 8 | Pad output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two things can land on the same line in the same cycle: an incoming edge being latched and a clear write to that line. The bench raises a rising edge on a line set for rising edges. It then times the clear write so that it is captured at the same clock edge that latches the synchronised edge, which is two edges after the pad changes. The raw status is read back afterwards, and bit 0 must still be 1. A second clear with no edge present must then bring it to 0.

// File: rtl/gpio_mask_irq_pkg.sv
package gpio_mask_irq_pkg;
  localparam int LINES_DEF = 8;

  // register index = addr[4:2] inside the control region
  typedef enum logic [2:0] {
    RG_DIR   = 3'd0,
    RG_SENSE = 3'd1,
    RG_BOTH  = 3'd2,
    RG_EVENT = 3'd3,
    RG_IE    = 3'd4,
    RG_RAW   = 3'd5,
    RG_MIS   = 3'd6,
    RG_CLR   = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_mi_sync.sv
module gpio_mi_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/gpio_mi_irq.sv
module gpio_mi_irq #(
  parameter int NL = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NL-1:0] sync_i,
  input  logic [NL-1:0] sense_i,
  input  logic [NL-1:0] both_i,
  input  logic [NL-1:0] event_i,
  input  logic [NL-1:0] clr_i,
  output logic [NL-1:0] edge_hit_o,
  output logic [NL-1:0] raw_o
);
  for (genvar g = 0; g < NL; g++) begin : g_line
    logic prev_q, lat_q, rise, fall;
    assign rise = sync_i[g] & ~prev_q;
    assign fall = ~sync_i[g] & prev_q;
    assign edge_hit_o[g] = ~sense_i[g] &
                           ((rise & (both_i[g] | event_i[g])) |
                            (fall & (both_i[g] | ~event_i[g])));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        lat_q  <= 1'b0;
      end else begin
        prev_q <= sync_i[g];
        // new edge takes priority over a clear
        if (edge_hit_o[g])  lat_q <= 1'b1;
        else if (clr_i[g])  lat_q <= 1'b0;
      end
    end
    assign raw_o[g] = sense_i[g] ? (sync_i[g] == event_i[g]) : lat_q;
  end
endmodule

// File: rtl/gpio_mi_regs.sv
module gpio_mi_regs
  import gpio_mask_irq_pkg::*;
#(
  parameter int NL = 8,
  parameter int AW = NL + 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NL-1:0] wdata_i,
  input  logic [NL-1:0] line_val_i,
  input  logic [NL-1:0] raw_i,
  output logic [NL-1:0] out_o,
  output logic [NL-1:0] dir_o,
  output logic [NL-1:0] sense_o,
  output logic [NL-1:0] both_o,
  output logic [NL-1:0] event_o,
  output logic [NL-1:0] ie_o,
  output logic [NL-1:0] clr_o,
  output logic [NL-1:0] rdata_o
);
  localparam int TOPB = AW - 1;

  logic          win_sel, reg_hit, wr, rd;
  logic [NL-1:0] mask;
  reg_idx_e      idx;
  logic [NL-1:0] out_q, dir_q, sense_q, both_q, event_q, ie_q;
  logic          unused_addr;

  assign win_sel     = (addr_i[TOPB -: 2] == 2'b00);
  assign reg_hit     = (addr_i[TOPB -: 2] == 2'b01) && (addr_i[TOPB-2:5] == '0);
  assign mask        = addr_i[NL+1:2];
  assign idx         = reg_idx_e'(addr_i[4:2]);
  assign wr          = req_i & we_i;
  assign rd          = req_i & ~we_i;
  assign unused_addr = ^addr_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      ie_q    <= '0;
    end else if (wr) begin
      if (win_sel) out_q <= (out_q & ~mask) | (wdata_i & mask);
      if (reg_hit) begin
        unique case (idx)
          RG_DIR:   dir_q   <= wdata_i;
          RG_SENSE: sense_q <= wdata_i;
          RG_BOTH:  both_q  <= wdata_i;
          RG_EVENT: event_q <= wdata_i;
          RG_IE:    ie_q    <= wdata_i;
          default:  ;
        endcase
      end
    end
  end

  assign clr_o = (wr && reg_hit && idx == RG_CLR) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    if (rd && win_sel) begin
      rdata_o = line_val_i & mask;
    end else if (rd && reg_hit) begin
      unique case (idx)
        RG_DIR:   rdata_o = dir_q;
        RG_SENSE: rdata_o = sense_q;
        RG_BOTH:  rdata_o = both_q;
        RG_EVENT: rdata_o = event_q;
        RG_IE:    rdata_o = ie_q;
        RG_RAW:   rdata_o = raw_i;
        RG_MIS:   rdata_o = raw_i & ie_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign out_o   = out_q;
  assign dir_o   = dir_q;
  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign event_o = event_q;
  assign ie_o    = ie_q;
endmodule

// File: rtl/gpio_mask_irq.sv
module gpio_mask_irq #(
  parameter int NL = gpio_mask_irq_pkg::LINES_DEF,
  parameter int AW = NL + 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NL-1:0] wdata_i,
  output logic [NL-1:0] rdata_o,
  input  logic [NL-1:0] gpio_i,
  output logic [NL-1:0] gpio_o,
  output logic [NL-1:0] gpio_oe_o,
  output logic          irq_o
);
  logic [NL-1:0] sync_in, out_q, dir_q, sense_q, both_q, event_q, ie_q;
  logic [NL-1:0] clr_pulse, edge_hit, raw_st, line_val;

  gpio_mi_sync #(.W(NL)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (gpio_i),
    .q_o    (sync_in)
  );

  assign line_val = (dir_q & out_q) | (~dir_q & sync_in);

  gpio_mi_regs #(.NL(NL), .AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .line_val_i (line_val),
    .raw_i      (raw_st),
    .out_o      (out_q),
    .dir_o      (dir_q),
    .sense_o    (sense_q),
    .both_o     (both_q),
    .event_o    (event_q),
    .ie_o       (ie_q),
    .clr_o      (clr_pulse),
    .rdata_o    (rdata_o)
  );

  gpio_mi_irq #(.NL(NL)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_in),
    .sense_i    (sense_q),
    .both_i     (both_q),
    .event_i    (event_q),
    .clr_i      (clr_pulse),
    .edge_hit_o (edge_hit),
    .raw_o      (raw_st)
  );

  assign gpio_o    = out_q;
  assign gpio_oe_o = dir_q;
  assign irq_o     = |(raw_st & ie_q);
endmodule

// File: rtl/gpio_mask_irq_chk.sv
module gpio_mask_irq_chk #(
  parameter int NL = 8,
  parameter int AW = NL + 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [NL-1:0] wdata_i,
  input logic [NL-1:0] rdata_o,
  input logic [NL-1:0] gpio_o,
  input logic [NL-1:0] gpio_oe_o,
  input logic          irq_o,
  input logic [NL-1:0] raw_i,
  input logic [NL-1:0] edge_hit_i,
  input logic [NL-1:0] clr_i,
  input logic [NL-1:0] sense_i
);
  localparam logic [AW-1:0] DIR_A = AW'(1) << (AW - 2);
  localparam logic [AW-1:0] MIS_A = DIR_A + AW'(24);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (irq_o == 1'b0 && gpio_oe_o == '0 && gpio_o == '0);
    end
  end

  assert_masked_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[AW-1 -: 2] == 2'b00)
      |=> ((gpio_o ^ $past(gpio_o)) & ~$past(addr_i[NL+1:2])) == '0);

  assert_dir_oe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == DIR_A) |=> gpio_oe_o == $past(wdata_i));

  assert_clear_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~sense_i & ~edge_hit_i))
      |=> (raw_i & $past(clr_i & ~sense_i & ~edge_hit_i)) == '0);

  assert_edge_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & edge_hit_i))
      |=> (raw_i & $past(clr_i & edge_hit_i)) == $past(clr_i & edge_hit_i));

  assert_irq_mis_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == MIS_A) |-> irq_o == (rdata_o != '0));
endmodule

bind gpio_mask_irq gpio_mask_irq_chk #(.NL(NL), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .gpio_o     (gpio_o),
  .gpio_oe_o  (gpio_oe_o),
  .irq_o      (irq_o),
  .raw_i      (raw_st),
  .edge_hit_i (edge_hit),
  .clr_i      (clr_pulse),
  .sense_i    (sense_q)
);

// File: tb/test_gpio_mask_irq.sv
module test_gpio_mask_irq;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_DIR = 12'h400, A_SENSE = 12'h404, A_BOTH = 12'h408,
                          A_EVENT = 12'h40C, A_IE = 12'h410, A_RAW = 12'h414,
                          A_MIS = 12'h418, A_CLR = 12'h41C, A_GAP = 12'h420;

  logic clk = 1'b0, rst_ni = 1'b1;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0] wdata = '0, rdata, pins = '0, gpio_o, gpio_oe;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] exp_q[$], got_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mask_irq i_gpio_mask_irq (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .gpio_i(pins), .gpio_o(gpio_o),
    .gpio_oe_o(gpio_oe), .irq_o(irq)
  );

  function automatic logic [11:0] win(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic push(input logic [7:0] got, input logic [7:0] exp, input string tag);
    got_q.push_back(got);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    push(rdata, exp, tag);
    req = 1'b0;
  endtask

  task automatic port_chk(input int which, input logic [7:0] exp, input string tag);
    @(negedge clk);
    #1;
    case (which)
      0: push(gpio_o, exp, tag);
      1: push(gpio_oe, exp, tag);
      default: push({7'd0, irq}, exp, tag);
    endcase
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(posedge clk);
  endtask

  // monitor: pops expected items and compares
  initial begin
    forever begin
      logic [7:0] g, e;
      string t;
      wait (exp_q.size() != 0);
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (g !== e) begin
        bad++;
        $display("FAIL %s: got=%02h expected=%02h", t, g, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset state
    rd_chk(A_DIR, 8'h00, "R1 dir");
    rd_chk(A_IE, 8'h00, "R1 ie");
    rd_chk(A_RAW, 8'h00, "R1 raw");
    port_chk(1, 8'h00, "R1 oe");
    port_chk(0, 8'h00, "R1 out");
    port_chk(2, 8'h00, "R1 irq");

    // R4 direction
    bus_wr(A_DIR, 8'hF0);
    port_chk(1, 8'hF0, "R4 oe");

    // R2 masked writes
    bus_wr(win(8'h3C), 8'hFF);
    port_chk(0, 8'h3C, "R2 set subset");
    bus_wr(win(8'h0F), 8'h00);
    port_chk(0, 8'h30, "R2 clear subset");

    // R3 masked reads: outputs from out reg, inputs from pads
    set_pins(8'hA5);
    rd_chk(win(8'hFF), 8'h35, "R3 full mask");
    rd_chk(win(8'h0C), 8'h04, "R3 partial mask");

    bus_wr(A_DIR, 8'h00);
    set_pins(8'h00);            // falling edges latch on 0,2,5,7 (event=0)
    rd_chk(A_RAW, 8'hA5, "R6 falling latched");
    bus_wr(A_CLR, 8'hFF);
    rd_chk(A_RAW, 8'h00, "R8 clear all");

    // R5 level high on line 1
    bus_wr(A_SENSE, 8'h02);
    bus_wr(A_EVENT, 8'h02);
    bus_wr(A_IE, 8'h02);
    rd_chk(A_RAW, 8'h00, "R5 idle");
    set_pins(8'h02);
    rd_chk(A_RAW, 8'h02, "R5 level high");
    port_chk(2, 8'h01, "R10 irq level");
    bus_wr(A_CLR, 8'h02);
    rd_chk(A_RAW, 8'h02, "R5 clear ignored on level");
    set_pins(8'h00);
    rd_chk(A_RAW, 8'h00, "R5 level gone");
    port_chk(2, 8'h00, "R10 irq drop");

    // R5 level low on line 2
    bus_wr(A_SENSE, 8'h06);
    rd_chk(A_RAW, 8'h04, "R5 level low");
    set_pins(8'h04);
    rd_chk(A_RAW, 8'h00, "R5 low removed");
    set_pins(8'h00);
    rd_chk(A_RAW, 8'h04, "R5 low again");
    bus_wr(A_SENSE, 8'h00);
    bus_wr(A_EVENT, 8'h00);
    rd_chk(A_RAW, 8'h00, "R5 back to edge");

    // R6 single edges
    bus_wr(A_IE, 8'hFF);
    bus_wr(A_EVENT, 8'h08);
    set_pins(8'h08);
    rd_chk(A_RAW, 8'h08, "R6 rising");
    rd_chk(A_MIS, 8'h08, "R10 mis");
    port_chk(2, 8'h01, "R10 irq edge");
    set_pins(8'h00);
    rd_chk(A_RAW, 8'h08, "R6 opposite edge");
    bus_wr(A_CLR, 8'h08);
    rd_chk(A_RAW, 8'h00, "R8 clear line3");
    port_chk(2, 8'h00, "R10 irq cleared");
    set_pins(8'h10);
    rd_chk(A_RAW, 8'h00, "R6 rise on falling line");
    set_pins(8'h00);
    rd_chk(A_RAW, 8'h10, "R6 falling");
    bus_wr(A_CLR, 8'h00);
    rd_chk(A_RAW, 8'h10, "R8 zero write no effect");
    bus_wr(A_CLR, 8'h10);
    rd_chk(A_RAW, 8'h00, "R8 clear line4");

    // R7 both edges, event bit set but ignored
    bus_wr(A_BOTH, 8'h20);
    bus_wr(A_EVENT, 8'h28);
    set_pins(8'h20);
    rd_chk(A_RAW, 8'h20, "R7 rise");
    bus_wr(A_CLR, 8'h20);
    set_pins(8'h00);
    rd_chk(A_RAW, 8'h20, "R7 fall despite event=1");
    bus_wr(A_CLR, 8'h20);
    rd_chk(A_RAW, 8'h00, "R8 clear line5");

    // R10 masking
    bus_wr(A_IE, 8'h00);
    set_pins(8'h08);
    rd_chk(A_RAW, 8'h08, "R10 raw unmasked");
    rd_chk(A_MIS, 8'h00, "R10 mis masked");
    port_chk(2, 8'h00, "R10 irq masked");
    bus_wr(A_IE, 8'h08);
    rd_chk(A_MIS, 8'h08, "R10 mis enabled");
    port_chk(2, 8'h01, "R10 irq enabled");
    set_pins(8'h00);
    bus_wr(A_CLR, 8'h08);

    // R9 edge and clear collide on line 0
    bus_wr(A_EVENT, 8'h29);
    @(negedge clk) pins = 8'h01;   // edge k: stage 1
    @(negedge clk);                // after k; next write lands at k+2
    bus_wr(A_CLR, 8'h01);
    rd_chk(A_RAW, 8'h01, "R9 edge wins");
    bus_wr(A_CLR, 8'h01);
    rd_chk(A_RAW, 8'h00, "R9 later clear");

    // R11 read-only and unmapped
    bus_wr(A_RAW, 8'hFF);
    bus_wr(A_MIS, 8'hFF);
    rd_chk(A_RAW, 8'h00, "R11 raw ignores write");
    rd_chk(A_MIS, 8'h00, "R11 mis ignores write");
    rd_chk(A_CLR, 8'h00, "R11 clear reads 0");
    rd_chk(A_GAP, 8'h00, "R11 unmapped");

    wait (exp_q.size() == 0);
    #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule